// File: doc/BRIEF.md
# SPI master with stalling FIFOs

This block is a single-slave SPI master. Software queues bytes in an eight-entry transmit FIFO through a small register interface. Once the enable bit is set, the shift engine sends the queued bytes MSB first, eight bits per frame. It drives the serial clock, MOSI and an active-low slave select, and it samples MISO. Each frame places exactly one received byte in an eight-entry receive FIFO, so software reads one byte back for every byte it sends, even when the received byte is only a dummy.

The receive side never loses data. If the receive FIFO is still full when a frame ends, the engine keeps the finished byte and waits before it starts another frame. It pushes the byte and carries on once software has read an entry. The two FIFOs are emptied from a separate buffer-control register. Clearing the enable bit stops the engine at once and releases slave select. Clock polarity, clock phase and an optional longer MOSI setup time are chosen in a command register. While a transfer is in progress, writes to that register are refused. The serial clock half-period is the `HALF_DIV` parameter, counted in system clocks.

The register map uses a 3-bit address. Offset 0 is control, 1 is buffer control, 2 is command, 3 is data and 4 is status. Writes take effect on the clock edge at which `reg_we` is high. Reads are combinational from `reg_addr`. A data read pops its entry on the edge at which `reg_re` is high.

Top module: `spi_fifo_master`

## Requirements
- R1: The transmit FIFO holds 8 bytes. A write to the data register (offset 3) while it is full drops the byte and sets a sticky overflow flag (status bit 3). Only a transmit FIFO reset clears that flag.
- R2: In the buffer-control register (offset 1), bit 7 holds the transmit FIFO empty and bit 6 holds the receive FIFO empty for as long as each bit is 1. Writing 0x00 releases both.
- R3: While control bit 0 (offset 0) is 1 and the transmit FIFO holds data, frames start. `ss_n` falls only while enable is set and stays low across back-to-back frames and after the last one.
- R4: Clearing the enable bit brings `ss_n` high and returns `sclk` to its idle level one clock after the register changes. A frame cut short this way pushes nothing into the receive FIFO.
- R5: Command bit 1 (offset 2) is the clock polarity and sets the idle level of `sclk`. Command bit 0 is the phase. With phase 0, MOSI changes on even clock edges and MISO is sampled on odd edges. With phase 1, MOSI changes on odd edges and MISO is sampled on even edges. Edges are counted from 1 within a frame, and bits go MSB first.
- R6: The first `sclk` edge of a frame comes `HALF_DIV` clocks after the frame is loaded. With command bit 2 set, it comes 3×`HALF_DIV` clocks after. Later edges are `HALF_DIV` clocks apart.
- R7: Each completed frame pushes exactly one received byte into the receive FIFO.
- R8: If the receive FIFO is full when a frame ends, the engine holds the byte, pushes nothing and starts no new frame until a read frees an entry. No received byte is lost.
- R9: Status (offset 4) reads bit 0 = transmit FIFO empty, bit 1 = receive FIFO not empty, bit 2 = transfer end (engine idle and transmit FIFO empty), bit 3 = overflow. After reset it reads 0x05.
- R10: Writes to the command register are ignored while enable is 1 and transfer end is 0.
- R11: A data-register read with the receive FIFO empty returns 0x00 and changes no state.
- R12: Data-register reads return received bytes in arrival order, one entry per read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register offset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops on data offset) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from reg_addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| ss_n | output | 1 | Active-low slave select |
| miso | input | 1 | Serial data from slave |

## Verification
The bound checker watches several properties on every cycle. It checks that slave select is released after a disable and never falls without enable, that nothing is pushed into a full receive FIFO, that the command register holds still during a transfer, and that a write into a full transmit FIFO raises the overflow flag. The bench's scenarios cover the rest. They check that bit order and clock edges are correct in all four polarity and phase modes, the lead time before the first edge with and without the setup extension, the stall and later resume with every byte kept in order, and the loss of an aborted frame. They also check the FIFO resets and the value returned by an empty read. A behavioural slave and a set of queues give the expected bytes, and the bench compares slave select and idle clock level with its model on every clock.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;

    localparam int REG_CTRL = 0;
    localparam int REG_BUF  = 1;
    localparam int REG_CMD  = 2;
    localparam int REG_DATA = 3;
    localparam int REG_STAT = 4;

    localparam int ST_TXE  = 0;
    localparam int ST_RXNE = 1;
    localparam int ST_TEND = 2;
    localparam int ST_OVF  = 3;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_SHIFT,
        ENG_DONE
    } eng_state_e;

    typedef struct packed {
        logic ext;
        logic cpol;
        logic cpha;
    } spi_mode_t;

    // edge numbers count from 1; odd = leading half of each bit
    function automatic logic samples_here(input logic cpha, input logic odd);
        return cpha ? !odd : odd;
    endfunction

    function automatic logic drives_here(input logic cpha, input logic odd,
                                         input logic first, input logic last);
        return cpha ? (odd && !first) : (!odd && !last);
    endfunction

endpackage

// File: rtl/spi_fm_fifo.sv
module spi_fm_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT  = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        empty   = (cnt_q == '0);
        full    = (cnt_q == FULL_CNT);
        do_push = push && !full && !clr;
        do_pop  = pop && !empty && !clr;
        rdata   = mem[rd_q];
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= bump(wr_q);
            if (do_pop)  rd_q <= bump(rd_q);
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/spi_fm_engine.sv
module spi_fm_engine
    import spi_fm_pkg::*;
#(
    parameter int W        = 8,
    parameter int HALF_DIV = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  spi_mode_t    mode,
    input  logic         tx_valid,
    input  logic [W-1:0] tx_data,
    output logic         tx_pop,
    input  logic         rx_full,
    output logic         rx_push,
    output logic [W-1:0] rx_data,
    output logic         idle,
    output logic         sclk,
    output logic         mosi,
    output logic         ss_n,
    input  logic         miso
);
    localparam int EDGES    = 2 * W;
    localparam int EW       = $clog2(EDGES + 1);
    localparam int LEAD_EXT = 3 * HALF_DIV;
    localparam int DW       = $clog2(LEAD_EXT + 1);
    localparam logic [DW-1:0] DIV_HALF = DW'(HALF_DIV - 1);
    localparam logic [DW-1:0] DIV_EXT  = DW'(LEAD_EXT - 1);
    localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES);
    localparam logic [EW-1:0] FIRST_EDGE = EW'(1);

    eng_state_e    st_q;
    logic [DW-1:0] div_q;
    logic [EW-1:0] edge_q, edge_nx;
    logic [W-1:0]  tx_sh_q, rx_sh_q;
    logic          sclk_q, mosi_q, ss_n_q;
    logic          tick, load, do_sample, do_drive;

    always_comb begin
        edge_nx   = edge_q + 1'b1;
        tick      = (st_q == ENG_SHIFT) && (div_q == '0);
        rx_push   = en && (st_q == ENG_DONE) && !rx_full;
        load      = en && tx_valid && ((st_q == ENG_IDLE) || rx_push);
        tx_pop    = load;
        do_sample = samples_here(mode.cpha, edge_nx[0]);
        do_drive  = drives_here(mode.cpha, edge_nx[0],
                                edge_nx == FIRST_EDGE, edge_nx == LAST_EDGE);
        rx_data   = rx_sh_q;
        idle      = (st_q == ENG_IDLE);
        sclk      = sclk_q;
        mosi      = mosi_q;
        ss_n      = ss_n_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ENG_IDLE;
            div_q   <= '0;
            edge_q  <= '0;
            tx_sh_q <= '0;
            rx_sh_q <= '0;
            sclk_q  <= 1'b0;
            mosi_q  <= 1'b0;
            ss_n_q  <= 1'b1;
        end else if (!en) begin
            st_q   <= ENG_IDLE;
            sclk_q <= mode.cpol;
            ss_n_q <= 1'b1;
        end else if (load) begin
            tx_sh_q <= tx_data;
            mosi_q  <= tx_data[W-1];
            ss_n_q  <= 1'b0;
            edge_q  <= '0;
            div_q   <= mode.ext ? DIV_EXT : DIV_HALF;
            st_q    <= ENG_SHIFT;
        end else begin
            case (st_q)
                ENG_IDLE: sclk_q <= mode.cpol;
                ENG_SHIFT: begin
                    if (tick) begin
                        sclk_q <= ~sclk_q;
                        edge_q <= edge_nx;
                        div_q  <= DIV_HALF;
                        if (do_sample) rx_sh_q <= {rx_sh_q[W-2:0], miso};
                        if (do_drive) begin
                            tx_sh_q <= tx_sh_q << 1;
                            mosi_q  <= tx_sh_q[W-2];
                        end
                        if (edge_nx == LAST_EDGE) st_q <= ENG_DONE;
                    end else begin
                        div_q <= div_q - 1'b1;
                    end
                end
                ENG_DONE: if (rx_push) st_q <= ENG_IDLE;
                default:  st_q <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import spi_fm_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 8,
    parameter int HALF_DIV   = 2,
    parameter int ADDR_W     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              sclk,
    output logic              mosi,
    output logic              ss_n,
    input  logic              miso
);
    localparam int MODE_W = $bits(spi_mode_t);

    logic        en_q, tx_rst_q, rx_rst_q, ovf_q;
    spi_mode_t   mode_q;
    logic        tx_empty, tx_full, rx_empty, rx_full;
    logic        tx_pop, rx_push, eng_idle, tend;
    logic        ctrl_wr, buf_wr, cmd_wr, data_wr, data_rd, cmd_locked;
    logic [DATA_W-1:0] tx_head, rx_head, rx_word;

    always_comb begin
        ctrl_wr    = reg_we && (reg_addr == ADDR_W'(REG_CTRL));
        buf_wr     = reg_we && (reg_addr == ADDR_W'(REG_BUF));
        cmd_wr     = reg_we && (reg_addr == ADDR_W'(REG_CMD));
        data_wr    = reg_we && (reg_addr == ADDR_W'(REG_DATA));
        data_rd    = reg_re && (reg_addr == ADDR_W'(REG_DATA));
        tend       = eng_idle && tx_empty;
        cmd_locked = en_q && !tend;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            tx_rst_q <= 1'b0;
            rx_rst_q <= 1'b0;
            ovf_q    <= 1'b0;
            mode_q   <= '0;
        end else begin
            if (ctrl_wr) en_q <= reg_wdata[0];
            if (buf_wr) begin
                tx_rst_q <= reg_wdata[DATA_W-1];
                rx_rst_q <= reg_wdata[DATA_W-2];
            end
            if (cmd_wr && !cmd_locked) mode_q <= spi_mode_t'(reg_wdata[MODE_W-1:0]);
            if (tx_rst_q)                ovf_q <= 1'b0;
            else if (data_wr && tx_full) ovf_q <= 1'b1;
        end
    end

    spi_fm_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .clr(tx_rst_q),
        .push(data_wr), .pop(tx_pop), .wdata(reg_wdata),
        .rdata(tx_head), .empty(tx_empty), .full(tx_full)
    );

    spi_fm_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .clr(rx_rst_q),
        .push(rx_push), .pop(data_rd), .wdata(rx_word),
        .rdata(rx_head), .empty(rx_empty), .full(rx_full)
    );

    spi_fm_engine #(.W(DATA_W), .HALF_DIV(HALF_DIV)) u_eng (
        .clk(clk), .rst(rst), .en(en_q), .mode(mode_q),
        .tx_valid(!tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_word),
        .idle(eng_idle), .sclk(sclk), .mosi(mosi), .ss_n(ss_n), .miso(miso)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_W'(REG_CTRL): reg_rdata[0] = en_q;
            ADDR_W'(REG_BUF): begin
                reg_rdata[DATA_W-1] = tx_rst_q;
                reg_rdata[DATA_W-2] = rx_rst_q;
            end
            ADDR_W'(REG_CMD):  reg_rdata[MODE_W-1:0] = mode_q;
            ADDR_W'(REG_DATA): reg_rdata = rx_empty ? '0 : rx_head;
            ADDR_W'(REG_STAT): begin
                reg_rdata[ST_TXE]  = tx_empty;
                reg_rdata[ST_RXNE] = !rx_empty;
                reg_rdata[ST_TEND] = tend;
                reg_rdata[ST_OVF]  = ovf_q;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       ss_n,
    input logic       tend,
    input logic       tx_full,
    input logic       data_wr,
    input logic       ovf,
    input logic       rx_full,
    input logic       rx_push,
    input logic [2:0] cmd
);
    // R4: disabled engine releases slave select on the next clock
    a_r4_ss_release: assert property (@(posedge clk) disable iff (rst)
        !en |=> ss_n);

    // R3: slave select only falls when enable was set
    a_r3_ss_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $fell(ss_n) |-> $past(en));

    // R8: never push into a full receive FIFO
    a_r8_no_push_full: assert property (@(posedge clk) disable iff (rst)
        rx_full |-> !rx_push);

    // R10: command register frozen while a transfer runs
    a_r10_cmd_locked: assert property (@(posedge clk) disable iff (rst)
        (en && !tend) |=> $stable(cmd));

    // R1: write into full transmit FIFO raises overflow
    a_r1_overflow_flag: assert property (@(posedge clk) disable iff (rst)
        (data_wr && tx_full) |=> ovf);
endmodule

bind spi_fifo_master spi_fifo_master_chk u_chk (
    .clk(clk), .rst(rst), .en(en_q), .ss_n(ss_n), .tend(tend),
    .tx_full(tx_full), .data_wr(data_wr), .ovf(ovf_q),
    .rx_full(rx_full), .rx_push(rx_push), .cmd(mode_q)
);

// File: tb/sim_spi_fifo_master.sv
`timescale 1ns/1ps
module sim_spi_fifo_master;
    localparam int HD = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] reg_addr = '0;
    logic       reg_we = 1'b0, reg_re = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sclk, mosi, ss_n;
    logic       miso = 1'b0;

    always #10 clk = ~clk;

    spi_fifo_master #(.HALF_DIV(HD)) u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_re(reg_re), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk(sclk), .mosi(mosi), .ss_n(ss_n), .miso(miso)
    );

    int errs = 0, checks = 0;
    bit en_m = 0, cpol_m = 0, cpha_m = 0, lock_exp = 0;
    bit e1 = 0, c1 = 0;
    logic [7:0] tx_exp[$];
    logic [7:0] rx_exp[$];
    int fidx = 0, frames = 0, cyc = 0, t_fall = 0, last_lead = -1, ecnt = 0;
    bit lead_arm = 0, sclk_p = 0, ss_p = 1;
    logic [7:0] cap = '0, p;
    bit done = 0;

    function automatic logic [7:0] pat(input int i);
        return 8'h3C ^ 8'(i * 29);
    endfunction

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // per-clock reference comparison and behavioural slave
    always @(negedge clk) begin
        if (rst) begin
            e1 = 0; c1 = 0;
        end else begin
            cyc++;
            if (!e1) begin
                chk(ss_n == 1'b1, "R4 ss_n high while disabled", ss_n, 1);
                chk(sclk == c1, "R5 sclk idle level", sclk, c1);
            end
            e1 = en_m;
            c1 = cpol_m;
            p = pat(fidx);
            if (ss_p && !ss_n) begin t_fall = cyc; lead_arm = 1; end
            if (ss_n) begin
                ecnt = 0;
                miso = p[7];
            end else if (sclk != sclk_p) begin
                ecnt++;
                if (lead_arm) begin last_lead = cyc - t_fall; lead_arm = 0; end
                if (cpha_m ? (ecnt % 2 == 0) : (ecnt % 2 == 1)) cap = {cap[6:0], mosi};
                if (!cpha_m && ecnt % 2 == 0 && ecnt < 16) miso = p[7 - ecnt / 2];
                if (cpha_m && ecnt % 2 == 1) miso = p[7 - (ecnt - 1) / 2];
                if (ecnt == 16) begin
                    if (tx_exp.size() == 0)
                        chk(0, "R5 unexpected frame on MOSI", cap, 0);
                    else begin
                        logic [7:0] e;
                        e = tx_exp.pop_front();
                        chk(cap == e, "R5 MOSI byte", cap, e);
                    end
                    rx_exp.push_back(p);
                    fidx++; frames++; ecnt = 0;
                    p = pat(fidx);
                    miso = p[7];
                end
            end
            sclk_p = sclk; ss_p = ss_n;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        #1;
        if (a == 3'd0) en_m = d[0];
        if (a == 3'd2 && !lock_exp) begin cpol_m = d[1]; cpha_m = d[0]; end
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_re = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic push_tx(input logic [7:0] d);
        wr(3'd3, d);
        tx_exp.push_back(d);
    endtask

    task automatic rd_data_chk();
        logic [7:0] d, e;
        rd(3'd3, d);
        if (rx_exp.size() == 0) chk(0, "R12 read with nothing expected", d, 0);
        else begin
            e = rx_exp.pop_front();
            chk(d == e, "R12 receive order", d, e);
        end
    endtask

    task automatic wait_tend();
        logic [7:0] s;
        int g;
        s = '0;
        for (g = 0; g < 4000; g++) begin
            rd(3'd4, s);
            if (s[2]) break;
        end
        chk(s[2] == 1'b1, "R9 transfer end reached", s, 8'h04);
    endtask

    task automatic wait_rx();
        logic [7:0] s;
        s = '0;
        for (int g = 0; g < 4000; g++) begin
            rd(3'd4, s);
            if (s[1]) break;
        end
        chk(s[1] == 1'b1, "R8 receive data resumes", s, 8'h02);
    endtask

    task automatic run_mode(input logic [7:0] cmdv, input int n, input int lead_exp);
        logic [7:0] s;
        wr(3'd2, cmdv);
        repeat (3) @(negedge clk);
        chk(sclk == cmdv[1], "R5 idle sclk follows polarity", sclk, cmdv[1]);
        last_lead = -1;
        for (int i = 0; i < n; i++) push_tx(8'h5A ^ 8'(i * 17) ^ cmdv);
        wr(3'd0, 8'h01);
        wait_tend();
        chk(ss_n == 1'b0, "R3 ss_n held low while enabled", ss_n, 0);
        chk(last_lead == lead_exp, "R6 lead time before first edge", last_lead, lead_exp);
        for (int i = 0; i < n; i++) rd_data_chk();
        rd(3'd4, s);
        chk(s == 8'h05, "R9 status after drain", s, 8'h05);
        wr(3'd0, 8'h00);
        repeat (3) @(negedge clk);
        chk(ss_n == 1'b1, "R4 ss_n released on disable", ss_n, 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL R3 watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] s, d;
        int f0, g;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        rd(3'd4, s);
        chk(s == 8'h05, "R9 status after reset", s, 8'h05);
        chk(ss_n == 1'b1 && sclk == 1'b0, "R3 outputs idle after reset", {ss_n, sclk}, 2'b10);

        // R11: empty read
        rd(3'd3, d);
        chk(d == 8'h00, "R11 empty read value", d, 0);
        rd(3'd4, s);
        chk(s == 8'h05, "R11 status unchanged by empty read", s, 8'h05);

        // R1 overflow with the engine disabled
        for (int i = 0; i < 10; i++) begin
            wr(3'd3, 8'hA0 + 8'(i));
        end
        rd(3'd4, s);
        chk(s == 8'h08, "R1 overflow flagged, FIFO holds data", s, 8'h08);
        wr(3'd1, 8'hC0);
        rd(3'd4, s);
        chk(s == 8'h05, "R2 tx reset empties FIFO and clears R1 overflow", s, 8'h05);
        wr(3'd1, 8'h00);
        rd(3'd1, d);
        chk(d == 8'h00, "R2 buffer control released", d, 0);

        // R5/R6: all four modes, with and without setup extension
        run_mode(8'h00, 3, HD);
        run_mode(8'h06, 2, 3 * HD);
        run_mode(8'h03, 2, HD);
        run_mode(8'h01, 3, HD);
        run_mode(8'h04, 1, 3 * HD);

        // R10: command write during a transfer is ignored
        wr(3'd2, 8'h00);
        for (int i = 0; i < 4; i++) push_tx(8'hC3 ^ 8'(i));
        wr(3'd0, 8'h01);
        repeat (10) @(negedge clk);
        lock_exp = 1;
        wr(3'd2, 8'h03);
        lock_exp = 0;
        rd(3'd2, d);
        chk(d == 8'h00, "R10 command locked while busy", d, 0);
        wait_tend();
        for (int i = 0; i < 4; i++) rd_data_chk();
        wr(3'd0, 8'h00);

        // R8: stall on a full receive FIFO, then resume without loss
        f0 = frames;
        for (int i = 0; i < 8; i++) push_tx(8'h11 * 8'(i + 1));
        wr(3'd0, 8'h01);
        wait_tend();
        chk(frames - f0 == 8, "R7 one frame per byte", frames - f0, 8);
        push_tx(8'hE1);
        push_tx(8'hE2);
        repeat (400) @(negedge clk);
        chk(frames - f0 == 9, "R8 engine stalls after ninth frame", frames - f0, 9);
        rd(3'd4, s);
        chk(s[0] == 1'b0 && s[2] == 1'b0, "R8 tenth byte still queued", s[2:0], 3'b010);
        chk(ss_n == 1'b0 && sclk == 1'b0, "R8 stalled with ss low, clock idle", {ss_n, sclk}, 0);
        for (int i = 0; i < 10; i++) begin
            wait_rx();
            rd_data_chk();
        end
        wait_tend();
        chk(frames - f0 == 10, "R8 all frames completed", frames - f0, 10);
        chk(rx_exp.size() == 0, "R7 every frame read back", rx_exp.size(), 0);
        wr(3'd0, 8'h00);

        // R4: abort a frame midway
        f0 = frames;
        push_tx(8'h96);
        wr(3'd0, 8'h01);
        g = 0;
        while (ecnt < 4 && g < 2000) begin @(negedge clk); g++; end
        wr(3'd0, 8'h00);
        repeat (5) @(negedge clk);
        void'(tx_exp.pop_front());
        rd(3'd4, s);
        chk(s == 8'h05, "R4 aborted frame pushes nothing", s, 8'h05);
        chk(frames == f0, "R4 no frame completed", frames - f0, 0);

        // R2: receive FIFO reset
        push_tx(8'h3A);
        push_tx(8'h5C);
        wr(3'd0, 8'h01);
        wait_tend();
        wr(3'd0, 8'h00);
        rd(3'd4, s);
        chk(s[1] == 1'b1, "R7 received bytes present", s[1], 1);
        wr(3'd1, 8'h40);
        rd(3'd4, s);
        chk(s[1] == 1'b0, "R2 rx reset empties receive FIFO", s[1], 0);
        wr(3'd1, 8'h00);
        rx_exp.delete();
        rd(3'd3, d);
        chk(d == 8'h00, "R11 read after rx reset", d, 0);

        chk(tx_exp.size() == 0, "R3 all queued bytes sent", tx_exp.size(), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule